// File: doc/BRIEF.md
# Binary-Tree 32:1 Serializer with Post-Tap Outputs

This block turns parallel words into a serial bit stream for a line driver that uses pre-emphasis. A word is captured on a load strobe. It then passes through a binary tree of 2:1 multiplexer levels: five levels for a 32-bit word. Each level halves the number of lanes and doubles the update rate. The final level has two lanes and flips between them on a two-bit-period phase, which models a half-rate clock that selects on both of its edges. The model advances one bit period per clock edge, and each tree level acts only on the edges that belong to its own rate. Bit 31 of each word goes out first.

Besides the main bit, the block drives the same stream delayed by one and by two bit periods, for the driver's two post-taps. Each of the three lines also has a complementary output. A small controller sets the frame alignment and gates the line, so the outputs stay at zero from reset until the first bit of the first word reaches the end of the tree. The controller has three states. ST_IDLE holds the bit counter at the frame boundary. The transition IDLE to FILL is taken on the first load strobe. ST_FILL waits while that word crosses the tree. The transition FILL to RUN is taken when the first bit arrives. ST_RUN streams without end, and only reset leaves it.

In ST_RUN a new word is taken only on the last bit period of a frame, so frames follow one another with no gap. A frame boundary with no strobe sends the previous word again.

Top module: `bintree_serializer`

## Requirements
- R1: In ST_IDLE, a strobe on `load_i` at any clock edge captures `word_i` and starts the first frame at that edge.
- R2: Each frame sends its word over 32 consecutive bit periods, most significant bit (bit 31) first and bit 0 last.
- R3: For a word captured at edge E, bit 31 appears on `ser_o` after edge E+5, and bit 31-k appears after edge E+5+k.
- R4: Once streaming, frames follow back to back with no idle bit. A strobe on the last bit period of a frame (32 edges after the previous capture) supplies the next word.
- R5: In ST_RUN and ST_FILL, a strobe that does not fall on a frame boundary is ignored, and the frame in flight is not disturbed.
- R6: A frame boundary with no strobe sends the previous word again, unchanged.
- R7: `ser_n_o`, `post1_n_o` and `post2_n_o` are always the exact inverses of `ser_o`, `post1_o` and `post2_o` in the same bit period.
- R8: `post1_o` equals `ser_o` of the previous bit period, and `post2_o` equals `ser_o` from two bit periods earlier.
- R9: From reset until the first bit of the first word is due, `ser_o`, `post1_o` and `post2_o` are 0 and the complementary outputs are 1.
- R10: A reset asserted in the middle of a stream drops all outputs to zero. After reset the block waits in ST_IDLE and takes its frame alignment from the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-period clock; one edge per serial bit |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | 32 | Parallel word to send |
| load_i | input | 1 | Load strobe from the word-rate domain |
| ser_o | output | 1 | Main serial bit |
| ser_n_o | output | 1 | Inverse of the main serial bit |
| post1_o | output | 1 | Main stream delayed one bit period (first post-tap) |
| post1_n_o | output | 1 | Inverse of the first post-tap |
| post2_o | output | 1 | Main stream delayed two bit periods (second post-tap) |
| post2_n_o | output | 1 | Inverse of the second post-tap |

## Verification
The first frame is the word 0x80000001, so an error of one bit period in latency or a reversed bit order shows up at once. Words of all ones, all zeros and the two alternating patterns follow. These separate lane swaps between the tree's halves from swaps between its even and odd lanes, and they show stuck lanes. After these comes a long run of random words sent back to back, with a few boundaries left without a strobe and a few strobes placed off the boundary. Together they separate "repeat the last word" from "load garbage" and "realign on any strobe". A reset in mid-stream followed by a short second session shows that the block realigns to the new strobe and does not keep the old phase.

// File: rtl/bintree_ser_pkg.sv
package bintree_ser_pkg;

    // Frame controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for the first load strobe
        ST_FILL = 2'd1,   // first word crossing the tree, line gated
        ST_RUN  = 2'd2    // continuous streaming
    } ser_state_e;

    // Start of tree level `level` inside the flat lane bus.
    // Level 0 is the captured word (word_w lanes), each level after it is half as wide.
    function automatic int level_offset(input int word_w, input int level);
        return 2 * word_w - 2 * (word_w >> level);
    endfunction

endpackage

// File: rtl/bintree_ser_ctrl.sv
module bintree_ser_ctrl
    import bintree_ser_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LOG_W  = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    output logic [LOG_W-1:0] ui_cnt_o,
    output logic             load_en_o,
    output logic             run_o
);

    localparam logic [LOG_W-1:0] CNT_LAST  = {LOG_W{1'b1}};
    // The first bit leaves the last level on the edge where the counter equals LOG_W-1
    localparam logic [LOG_W-1:0] FILL_LAST = LOG_W'(LOG_W - 1);

    ser_state_e       state_q;
    ser_state_e       state_d;
    logic [LOG_W-1:0] cnt_q;
    logic             at_boundary;

    assign at_boundary = (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Bit-period counter: parked on the boundary while idle, free-running otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_LAST;
        end else if (state_d == ST_IDLE) begin
            cnt_q <= CNT_LAST;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (load_i) state_d = ST_FILL;
            ST_FILL: if (cnt_q == FILL_LAST) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        load_en_o = 1'b0;
        run_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: load_en_o = load_i;
            ST_FILL: load_en_o = load_i && at_boundary;
            ST_RUN: begin
                load_en_o = load_i && at_boundary;
                run_o     = 1'b1;
            end
            default: begin
                load_en_o = 1'b0;
                run_o     = 1'b0;
            end
        endcase
    end

    assign ui_cnt_o = cnt_q;

endmodule

// File: rtl/bintree_ser_latch.sv
module bintree_ser_latch #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] lanes_o
);

    // Lane m carries transmit slot m, so the word's MSB lands on lane 0
    logic [WORD_W-1:0] slot_order;
    logic [WORD_W-1:0] lanes_q;

    for (genvar m = 0; m < WORD_W; m++) begin : g_rev
        assign slot_order[m] = word_i[WORD_W-1-m];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
        end else if (load_en) begin
            lanes_q <= slot_order;
        end
    end

    assign lanes_o = lanes_q;

endmodule

// File: rtl/bintree_ser_stage.sv
module bintree_ser_stage #(
    parameter int IN_W  = 32,
    parameter int LOG_W = 5,
    parameter int SKEW  = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LOG_W-1:0]   phase_i,
    input  logic [IN_W-1:0]    lanes_i,
    output logic [IN_W/2-1:0]  lanes_o
);

    localparam int               OUT_W    = IN_W / 2;
    localparam int               HALF_BIT = $clog2(IN_W) - 1;
    localparam logic [LOG_W-1:0] LOW_MASK = LOG_W'((1 << HALF_BIT) - 1);
    localparam logic [LOG_W-1:0] SKEW_V   = LOG_W'(SKEW);

    // Input lane j carries slots j mod IN_W; output lane j carries slots j mod OUT_W.
    // Each output update window of OUT_W bit periods takes the lower half of the
    // inputs first, then the upper half. With IN_W = 2 the window is one bit period
    // and the select bit is a half-rate phase, which stands for the dual-edge last stage.
    logic [LOG_W-1:0] local_ph;
    logic             take;
    logic             upper;
    logic [OUT_W-1:0] pick;
    logic [OUT_W-1:0] lanes_q;

    assign local_ph = phase_i - SKEW_V;
    assign take     = ((local_ph & LOW_MASK) == '0);
    assign upper    = local_ph[HALF_BIT];
    assign pick     = upper ? lanes_i[IN_W-1:OUT_W] : lanes_i[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lanes_q <= '0;
        end else if (take) begin
            lanes_q <= pick;
        end
    end

    assign lanes_o = lanes_q;

endmodule

// File: rtl/bintree_ser_taps.sv
module bintree_ser_taps #(
    parameter int TAPS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_i,
    output logic [TAPS:0] tap_o
);

    logic [TAPS:1] dly_q;
    logic [TAPS:0] src;

    assign src = {dly_q, bit_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else begin
            for (int i = 1; i <= TAPS; i++) begin
                dly_q[i] <= src[i-1];
            end
        end
    end

    assign tap_o = src;

endmodule

// File: rtl/bintree_serializer.sv
module bintree_serializer
    import bintree_ser_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    input  logic              load_i,
    output logic              ser_o,
    output logic              ser_n_o,
    output logic              post1_o,
    output logic              post1_n_o,
    output logic              post2_o,
    output logic              post2_n_o
);

    localparam int LOG_W    = $clog2(WORD_W);
    localparam int BUS_W    = 2 * WORD_W - 1;
    localparam int LAST_OFF = level_offset(WORD_W, LOG_W);
    localparam int TAPS     = 2;

    logic [LOG_W-1:0] ui_cnt;
    logic             load_en;
    logic             run_q;
    logic [BUS_W-1:0] tree_bus;
    logic             line_bit;
    logic [TAPS:0]    taps;

    bintree_ser_ctrl #(
        .WORD_W (WORD_W),
        .LOG_W  (LOG_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_i),
        .ui_cnt_o  (ui_cnt),
        .load_en_o (load_en),
        .run_o     (run_q)
    );

    bintree_ser_latch #(
        .WORD_W (WORD_W)
    ) latch_i (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .word_i  (word_i),
        .lanes_o (tree_bus[WORD_W-1:0])
    );

    // One 2:1 level per generate pass; level s works SKEW = s bit periods behind level 0
    for (genvar s = 0; s < LOG_W; s++) begin : g_level
        localparam int IN_W    = WORD_W >> s;
        localparam int IN_OFF  = level_offset(WORD_W, s);
        localparam int OUT_OFF = level_offset(WORD_W, s + 1);

        bintree_ser_stage #(
            .IN_W  (IN_W),
            .LOG_W (LOG_W),
            .SKEW  (s)
        ) stage_i (
            .clk     (clk),
            .rst     (rst),
            .phase_i (ui_cnt),
            .lanes_i (tree_bus[IN_OFF +: IN_W]),
            .lanes_o (tree_bus[OUT_OFF +: IN_W/2])
        );
    end

    // Line stays at zero until the controller reports the first bit has arrived
    assign line_bit = run_q & tree_bus[LAST_OFF];

    bintree_ser_taps #(
        .TAPS (TAPS)
    ) taps_i (
        .clk   (clk),
        .rst   (rst),
        .bit_i (line_bit),
        .tap_o (taps)
    );

    assign ser_o     = taps[0];
    assign ser_n_o   = ~taps[0];
    assign post1_o   = taps[1];
    assign post1_n_o = ~taps[1];
    assign post2_o   = taps[2];
    assign post2_n_o = ~taps[2];

endmodule

// File: rtl/bintree_serializer_chk.sv
module bintree_serializer_chk #(
    parameter int WORD_W = 32,
    parameter int LOG_W  = $clog2(WORD_W)
) (
    input logic             clk,
    input logic             rst,
    input logic             ser_o,
    input logic             post1_o,
    input logic             post2_o,
    input logic             run_i,
    input logic [LOG_W-1:0] ui_cnt_i
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !run_i |-> (!ser_o && !post1_o && !post2_o)); // R9

    AST_POST1_DELAY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (post1_o == $past(ser_o))); // R8

    AST_POST2_DELAY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (post2_o == $past(post1_o))); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        run_i |=> run_i); // R4

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (run_i && (ui_cnt_i == {LOG_W{1'b1}})) |=> (ui_cnt_i == '0)); // R4

    AST_FIRST_BIT_ALIGN: assert property (@(posedge clk) disable iff (rst)
        $rose(run_i) |-> (ui_cnt_i == LOG_W'(LOG_W))); // R3

endmodule

bind bintree_serializer bintree_serializer_chk #(
    .WORD_W (WORD_W)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ser_o    (ser_o),
    .post1_o  (post1_o),
    .post2_o  (post2_o),
    .run_i    (run_q),
    .ui_cnt_i (ui_cnt)
);

// File: tb/bintree_serializer_tb_top.sv
module bintree_serializer_tb_top;

    localparam int W    = 32;
    localparam int LAT  = 5;
    localparam int MAXF = 64;

    logic         clk  = 1'b0;
    logic         rst  = 1'b1;
    logic         load = 1'b0;
    logic [W-1:0] word = '0;
    logic ser_o, ser_n_o, post1_o, post1_n_o, post2_o, post2_n_o;

    int   checks = 0;
    int   errors = 0;
    logic done   = 1'b0;

    logic [W-1:0] frame_word [MAXF];
    string        frame_tag  [MAXF];

    always #10 clk = ~clk;

    bintree_serializer #(.WORD_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .word_i    (word),
        .load_i    (load),
        .ser_o     (ser_o),
        .ser_n_o   (ser_n_o),
        .post1_o   (post1_o),
        .post1_n_o (post1_n_o),
        .post2_o   (post2_o),
        .post2_n_o (post2_n_o)
    );

    // Expected line bit after edge E+t (E = first capture edge of the session)
    function automatic logic exp_bit(input int t);
        if (t < LAT) return 1'b0;
        return frame_word[(t - LAT) / W][W - 1 - ((t - LAT) % W)];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_quiet(input string req, input string what);
        logic [5:0] act;
        act = {ser_o, post1_o, post2_o, ser_n_o, post1_n_o, post2_n_o};
        check(act == 6'b000111, req, what, W'(act), W'(6'b000111));
    endtask

    function automatic logic [W-1:0] directed_word(input int f);
        case (f)
            0:       return 32'h8000_0001;
            1:       return 32'hFFFF_FFFF;
            2:       return 32'h0000_0000;
            3:       return 32'hAAAA_AAAA;
            4:       return 32'h5555_5555;
            default: return 32'h1234_5678;
        endcase
    endfunction

    // One session: idle_n idle cycles, then nf frames; t counts edges from the first capture
    task automatic run_session(input int nf, input int idle_n, input bit directed,
                               input string sess_tag);
        logic [W-1:0] rx;
        logic [W-1:0] w;
        int tap_bad;
        int cmp_bad;
        int f;
        int k;
        int nxt;
        int fb;
        rx = '0;
        tap_bad = 0;
        cmp_bad = 0;
        for (int t = -idle_n; t < LAT + W * nf; t++) begin
            @(negedge clk);
            // sample the outputs after edge E+t
            if (t < LAT) begin
                check_quiet(sess_tag, $sformatf("line quiet before first bit t=%0d", t)); // R9 / R10
            end else begin
                f  = (t - LAT) / W;
                k  = (t - LAT) % W;
                rx = {rx[W-2:0], ser_o};
                if (t == LAT)
                    check(ser_o == frame_word[0][W-1], "R3", "first bit latency",
                          W'(ser_o), W'(frame_word[0][W-1]));
                if ({post1_o, post2_o} != {exp_bit(t - 1), exp_bit(t - 2)}) tap_bad++;
                if ((ser_n_o == ser_o) || (post1_n_o == post1_o) || (post2_n_o == post2_o)) cmp_bad++;
                if (k == W - 1) begin
                    check(rx == frame_word[f], frame_tag[f], $sformatf("frame %0d word", f),
                          rx, frame_word[f]);
                    check(tap_bad == 0, "R8", $sformatf("frame %0d post-tap mismatches", f),
                          W'(tap_bad), '0);
                    check(cmp_bad == 0, "R7", $sformatf("frame %0d complement mismatches", f),
                          W'(cmp_bad), '0);
                    tap_bad = 0;
                    cmp_bad = 0;
                end
            end
            // drive the inputs for edge E+t+1
            load = 1'b0;
            word = $urandom;
            nxt  = t + 1;
            if (nxt >= 0 && (nxt % W) == 0) begin
                fb = nxt / W;
                if (fb < nf) begin
                    if (fb > 0 && ((directed && fb == 6) || (fb >= 9 && ($urandom % 7) == 0))) begin
                        frame_word[fb] = frame_word[fb - 1];          // R6
                        frame_tag[fb]  = "R6";
                    end else begin
                        w = (directed && fb < 6) ? directed_word(fb) : W'($urandom);
                        load = 1'b1;
                        word = w;
                        frame_word[fb] = w;
                        if (!directed)    frame_tag[fb] = sess_tag;
                        else if (fb == 0) frame_tag[fb] = "R1";
                        else if (fb < 6)  frame_tag[fb] = "R2";
                        else              frame_tag[fb] = "R4";
                    end
                end
            end else if (nxt > 0) begin
                fb = nxt / W;
                if (fb < nf && frame_tag[fb] != "R6" &&
                    ((directed && fb == 7 && (nxt % 3) == 0) || (fb >= 8 && ($urandom % 12) == 0))) begin
                    load = 1'b1;                                     // R5 off-boundary strobe
                    word = ~frame_word[fb];
                    frame_tag[fb] = "R5";
                end
            end
        end
        load = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7321));
        rst  = 1'b1;
        load = 1'b0;
        repeat (2) @(negedge clk);
        repeat (2) begin
            @(negedge clk);
            check_quiet("R9", "outputs during reset");
        end
        rst = 1'b0;

        run_session(40, 7, 1'b1, "R9");

        // R10: reset in the middle of the stream, with a strobe held high
        rst  = 1'b1;
        load = 1'b1;
        word = 32'hDEAD_BEEF;
        repeat (3) begin
            @(negedge clk);
            check_quiet("R10", "outputs during mid-stream reset");
        end
        rst  = 1'b0;
        load = 1'b0;

        run_session(4, 3, 1'b0, "R10");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule